// File: doc/BRIEF.md
# Shifter Operand Unit with Carry

This block forms the second operand of a 32-bit processor datapath, together with the carry that the shifter produces. A 12-bit operand field selects between two forms. The first is an 8-bit constant rotated right by an even amount. The second is a shift of the register value `rm_val`, whose amount comes either from the field itself or from the low byte of a second register (`rs_low`). The unit decodes every special encoding of a zero or oversized amount. These include a shift of 32, sign fill, rotate-through-carry by one, and the register-amount rules for 0, 32 and above.

A move-not select inverts the final operand. A small flag stage sits behind the shifter. When set-flags is active, it produces the next negative, zero and carry flags from the operand and the shifter carry. When the destination index is 15, it does not update the flags and instead raises `restore_req`, which asks the surrounding core to restore status from its saved copy.

The unit is purely combinational and carries no data stream, so it has no valid/ready handshake. The register file, the ALU and the restore itself lie outside it. All outputs follow the inputs within the same cycle.

Top module: `sop_unit`

## Requirements
- R1: With `use_imm`=1 the operand is `opnd_field[7:0]`, zero-extended and rotated right by 2×`opnd_field[11:8]`.
- R2: With `use_imm`=1 the shifter carry is bit 31 of the rotated constant when `opnd_field[11:8]`≠0, and `c_in` when it is 0.
- R3: With `use_imm`=0, `opnd_field[6:5]` picks the shift (00 LSL, 01 LSR, 10 ASR, 11 ROR). `opnd_field[4]`=0 takes the amount n from `opnd_field[11:7]`, and `opnd_field[4]`=1 takes it from `rs_low`. For 1≤n≤31 the result is the ordinary shift of `rm_val`. The carry is `rm_val[32-n]` for LSL and `rm_val[n-1]` for the other three.
- R4: An immediate-amount LSL by 0 returns `rm_val` unchanged with carry `c_in`.
- R5: An immediate-amount LSR coded 0 yields 0 with carry `rm_val[31]`. An immediate-amount ASR coded 0 yields 32 copies of `rm_val[31]` with carry `rm_val[31]`.
- R6: An immediate-amount ROR coded 0 yields {`c_in`, `rm_val[31:1]`} with carry `rm_val[0]`.
- R7: A register amount of 0 returns `rm_val` unchanged with carry `c_in`, for every shift type.
- R8: A register LSL or LSR by 32 or more yields 0. At exactly 32 the carry is `rm_val[0]` for LSL and `rm_val[31]` for LSR. Above 32 the carry is 0.
- R9: A register ASR by 32 or more yields 32 copies of `rm_val[31]` with carry `rm_val[31]`.
- R10: A register ROR rotates by `rs_low[4:0]`. If those bits are 0 but `rs_low`≠0, the result is `rm_val` with carry `rm_val[31]`.
- R11: With `mov_not`=1 the operand is the bitwise inverse of the shifter result. `shift_c` is unaffected.
- R12: With `set_flags`=1 and `dest_idx`≠15, the outputs are `n_next`=operand[31], `z_next`=(operand==0) and `c_next`=`shift_c`. With `set_flags`=0 the next flags equal `n_in`, `z_in` and `c_in`, and `restore_req`=0.
- R13: With `set_flags`=1 and `dest_idx`=15, `restore_req`=1 and the next flags equal the incoming ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_field | input | 12 | Operand encoding field |
| use_imm | input | 1 | 1 selects the rotated-constant form |
| rm_val | input | 32 | Value of the shifted register |
| rs_low | input | 8 | Low byte of the amount register |
| c_in | input | 1 | Current carry flag |
| n_in | input | 1 | Current negative flag |
| z_in | input | 1 | Current zero flag |
| mov_not | input | 1 | Invert the final operand |
| set_flags | input | 1 | Request a flag update |
| dest_idx | input | 4 | Destination register index |
| operand | output | 32 | Second operand |
| shift_c | output | 1 | Shifter carry-out |
| n_next | output | 1 | Next negative flag |
| z_next | output | 1 | Next zero flag |
| c_next | output | 1 | Next carry flag |
| restore_req | output | 1 | Status restore requested instead of a flag update |

## Verification
Every output is due in the same cycle that its inputs are applied, because no register lies on any path. The bench changes the inputs on the falling clock edge. It compares the operand, the carry, the flags and the restore request one time unit later, against a behavioural model written as a plain case analysis of the requirements. The sweep covers every shift type at amounts 0, 1, 31, 32, 33 and 255, all sixteen rotate values, and randomized mixes of the invert, set-flags and destination inputs.

// File: rtl/sop_pkg.sv
`timescale 1ns/1ps
package sop_pkg;
  typedef enum logic [1:0] {
    SH_LSL = 2'b00,
    SH_LSR = 2'b01,
    SH_ASR = 2'b10,
    SH_ROR = 2'b11
  } shift_kind_e;
endpackage

// File: rtl/sop_barrel.sv
`timescale 1ns/1ps
// Core shifter: amounts 0..DW, carry is the last bit moved out.
module sop_barrel
  import sop_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = $clog2(DW) + 1
) (
  input  shift_kind_e   kind,
  input  logic [DW-1:0] val,
  input  logic [AW-1:0] amt,
  output logic [DW-1:0] res,
  output logic          cout
);
  logic [DW:0]          wide_l;
  logic [DW:0]          wide_r;
  logic signed [DW:0]   wide_a;
  logic [2*DW-1:0]      dbl;

  always_comb begin
    wide_l = {1'b0, val} << amt;
    wide_r = {val, 1'b0} >> amt;
    wide_a = $signed({val, 1'b0}) >>> amt;
    dbl    = {val, val} >> amt;
    res    = '0;
    cout   = 1'b0;
    case (kind)
      SH_LSL: begin res = wide_l[DW-1:0]; cout = wide_l[DW]; end
      SH_LSR: begin res = wide_r[DW:1];   cout = wide_r[0];  end
      SH_ASR: begin res = wide_a[DW:1];   cout = wide_a[0];  end
      default: begin res = dbl[DW-1:0];   cout = dbl[DW-1];  end
    endcase
  end
endmodule

// File: rtl/sop_imm_rot.sv
`timescale 1ns/1ps
module sop_imm_rot
  import sop_pkg::*;
#(
  parameter int DW = 32,
  parameter int IW = 8,
  parameter int RW = 4,
  parameter int AW = $clog2(DW) + 1
) (
  input  logic [IW-1:0] imm_bits,
  input  logic [RW-1:0] rot_bits,
  input  logic          c_in,
  output logic [DW-1:0] value,
  output logic          cout
);
  logic [AW-1:0] rot_amt;
  logic          bar_c;

  assign rot_amt = AW'({rot_bits, 1'b0});

  sop_barrel #(.DW(DW), .AW(AW)) u_rot (
    .kind (SH_ROR),
    .val  (DW'(imm_bits)),
    .amt  (rot_amt),
    .res  (value),
    .cout (bar_c)
  );

  assign cout = (rot_bits == '0) ? c_in : bar_c;

  always_comb begin
    if (rot_bits == '0) begin
      a_r2_zero_rot: assert (value == DW'(imm_bits) && cout == c_in)
        else $error("R2: unrotated constant or carry wrong");
    end
  end
endmodule

// File: rtl/sop_shift_dec.sv
`timescale 1ns/1ps
// Maps immediate and register amounts, including special codes, onto the barrel.
module sop_shift_dec
  import sop_pkg::*;
#(
  parameter int DW  = 32,
  parameter int SAW = 5,
  parameter int RAW = 8,
  parameter int AW  = $clog2(DW) + 1
) (
  input  logic [DW-1:0]  rm,
  input  shift_kind_e    kind,
  input  logic           reg_mode,
  input  logic [SAW-1:0] imm_amt,
  input  logic [RAW-1:0] reg_amt,
  input  logic           c_in,
  output logic [DW-1:0]  res,
  output logic           cout
);
  localparam logic [AW-1:0]  FULL_AW  = AW'(DW);
  localparam logic [RAW-1:0] FULL_RAW = RAW'(DW);

  logic [AW-1:0] b_amt;
  logic          pass_thru, rrx, zero_all;
  logic [DW-1:0] b_res;
  logic          b_c;

  always_comb begin
    b_amt     = '0;
    pass_thru = 1'b0;
    rrx       = 1'b0;
    zero_all  = 1'b0;
    if (!reg_mode) begin
      case (kind)
        SH_LSL: begin
          pass_thru = (imm_amt == '0);
          b_amt     = AW'(imm_amt);
        end
        SH_LSR, SH_ASR: b_amt = (imm_amt == '0) ? FULL_AW : AW'(imm_amt);
        default: begin
          rrx   = (imm_amt == '0);
          b_amt = AW'(imm_amt);
        end
      endcase
    end else if (reg_amt == '0) begin
      pass_thru = 1'b1;
    end else begin
      case (kind)
        SH_LSL, SH_LSR: begin
          zero_all = (reg_amt > FULL_RAW);
          b_amt    = zero_all ? '0 : AW'(reg_amt);
        end
        SH_ASR:  b_amt = (reg_amt >= FULL_RAW) ? FULL_AW : AW'(reg_amt);
        default: b_amt = AW'(reg_amt[AW-2:0]);
      endcase
    end
  end

  sop_barrel #(.DW(DW), .AW(AW)) u_bar (
    .kind (kind),
    .val  (rm),
    .amt  (b_amt),
    .res  (b_res),
    .cout (b_c)
  );

  always_comb begin
    if (pass_thru) begin
      res = rm;                 cout = c_in;
    end else if (rrx) begin
      res = {c_in, rm[DW-1:1]}; cout = rm[0];
    end else if (zero_all) begin
      res = '0;                 cout = 1'b0;
    end else begin
      res = b_res;              cout = b_c;
    end
  end

  always_comb begin
    if (reg_mode && kind == SH_ASR && reg_amt >= FULL_RAW) begin
      a_r9_asr_fill: assert (res == {DW{rm[DW-1]}} && cout == rm[DW-1])
        else $error("R9: oversized arithmetic shift wrong");
    end
    if (reg_mode && (kind == SH_LSL || kind == SH_LSR) && reg_amt > FULL_RAW) begin
      a_r8_big_zero: assert (res == '0 && !cout)
        else $error("R8: oversized logical shift not zero");
    end
    if (!reg_mode && kind == SH_ROR && imm_amt == '0) begin
      a_r6_rrx: assert (res[DW-1] == c_in && cout == rm[0])
        else $error("R6: rotate-through-carry wrong");
    end
  end
endmodule

// File: rtl/sop_flag_upd.sv
`timescale 1ns/1ps
module sop_flag_upd #(
  parameter int DW     = 32,
  parameter int IXW    = 4,
  parameter int PC_IDX = 15
) (
  input  logic [DW-1:0]  result,
  input  logic           shift_c,
  input  logic           set_flags,
  input  logic [IXW-1:0] dest_idx,
  input  logic           n_in,
  input  logic           z_in,
  input  logic           c_in,
  output logic           n_next,
  output logic           z_next,
  output logic           c_next,
  output logic           restore_req
);
  logic to_pc;
  assign to_pc = (dest_idx == IXW'(PC_IDX));

  always_comb begin
    n_next      = n_in;
    z_next      = z_in;
    c_next      = c_in;
    restore_req = 1'b0;
    if (set_flags) begin
      if (to_pc) begin
        restore_req = 1'b1;
      end else begin
        n_next = result[DW-1];
        z_next = (result == '0);
        c_next = shift_c;
      end
    end
  end

  always_comb begin
    if (restore_req) begin
      a_r13_restore_hold: assert (n_next == n_in && z_next == z_in && c_next == c_in)
        else $error("R13: flags changed during restore request");
    end
  end
endmodule

// File: rtl/sop_unit.sv
`timescale 1ns/1ps
module sop_unit
  import sop_pkg::*;
#(
  parameter int DW  = 32,
  parameter int FW  = 12,
  parameter int RAW = 8,
  parameter int IXW = 4
) (
  input  logic [FW-1:0]  opnd_field,
  input  logic           use_imm,
  input  logic [DW-1:0]  rm_val,
  input  logic [RAW-1:0] rs_low,
  input  logic           c_in,
  input  logic           n_in,
  input  logic           z_in,
  input  logic           mov_not,
  input  logic           set_flags,
  input  logic [IXW-1:0] dest_idx,
  output logic [DW-1:0]  operand,
  output logic           shift_c,
  output logic           n_next,
  output logic           z_next,
  output logic           c_next,
  output logic           restore_req
);
  localparam int IW  = 8;
  localparam int RW  = FW - IW;
  localparam int SAW = 5;

  logic [DW-1:0] imm_val, sh_val, raw_val;
  logic          imm_c, sh_c;
  logic          unused_idx;

  assign unused_idx = ^opnd_field[3:0];

  sop_imm_rot #(.DW(DW), .IW(IW), .RW(RW)) u_imm (
    .imm_bits (opnd_field[IW-1:0]),
    .rot_bits (opnd_field[FW-1:IW]),
    .c_in     (c_in),
    .value    (imm_val),
    .cout     (imm_c)
  );

  sop_shift_dec #(.DW(DW), .SAW(SAW), .RAW(RAW)) u_shift (
    .rm       (rm_val),
    .kind     (shift_kind_e'(opnd_field[6:5])),
    .reg_mode (opnd_field[4]),
    .imm_amt  (opnd_field[FW-1:FW-SAW]),
    .reg_amt  (rs_low),
    .c_in     (c_in),
    .res      (sh_val),
    .cout     (sh_c)
  );

  assign raw_val = use_imm ? imm_val : sh_val;
  assign shift_c = use_imm ? imm_c : sh_c;
  assign operand = mov_not ? ~raw_val : raw_val;

  sop_flag_upd #(.DW(DW), .IXW(IXW)) u_flags (
    .result      (operand),
    .shift_c     (shift_c),
    .set_flags   (set_flags),
    .dest_idx    (dest_idx),
    .n_in        (n_in),
    .z_in        (z_in),
    .c_in        (c_in),
    .n_next      (n_next),
    .z_next      (z_next),
    .c_next      (c_next),
    .restore_req (restore_req)
  );

  always_comb begin
    if (!use_imm && opnd_field[4] && rs_low == '0) begin
      a_r7_zero_amount: assert (operand == (mov_not ? ~rm_val : rm_val) && shift_c == c_in)
        else $error("R7: zero register amount altered value");
    end
    if (set_flags && !restore_req) begin
      a_r12_zero_flag: assert (z_next == (operand == '0) && n_next == operand[DW-1])
        else $error("R12: N/Z do not track operand");
    end
  end
endmodule

// File: tb/sop_unit_test.sv
`timescale 1ns/1ps
module sop_unit_test;
  logic        clk = 1'b0;
  logic [11:0] opnd_field;
  logic        use_imm;
  logic [31:0] rm_val;
  logic [7:0]  rs_low;
  logic        c_in, n_in, z_in, mov_not, set_flags;
  logic [3:0]  dest_idx;
  logic [31:0] operand;
  logic        shift_c, n_next, z_next, c_next, restore_req;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  sop_unit uut (
    .opnd_field (opnd_field), .use_imm (use_imm), .rm_val (rm_val),
    .rs_low (rs_low), .c_in (c_in), .n_in (n_in), .z_in (z_in),
    .mov_not (mov_not), .set_flags (set_flags), .dest_idx (dest_idx),
    .operand (operand), .shift_c (shift_c), .n_next (n_next),
    .z_next (z_next), .c_next (c_next), .restore_req (restore_req)
  );

  // Behavioural reference: a direct case analysis of R1..R10.
  function automatic void ref_shift(input logic [11:0] f, input logic imm,
      input logic [31:0] rm, input logic [7:0] rs, input logic c,
      output logic [31:0] r, output logic co, output string tag);
    int n;
    int k;
    logic [31:0] cst;
    if (imm) begin
      n   = 2 * int'(f[11:8]);
      cst = {24'd0, f[7:0]};
      if (n == 0) begin r = cst; co = c; tag = "R1/R2"; end
      else begin r = (cst >> n) | (cst << (32 - n)); co = r[31]; tag = "R1/R2"; end
      return;
    end
    if (!f[4]) begin
      n = int'(f[11:7]);
      case (f[6:5])
        2'b00: if (n == 0) begin r = rm; co = c; tag = "R4"; end
               else begin r = rm << n; co = rm[32 - n]; tag = "R3"; end
        2'b01: if (n == 0) begin r = 32'd0; co = rm[31]; tag = "R5"; end
               else begin r = rm >> n; co = rm[n - 1]; tag = "R3"; end
        2'b10: if (n == 0) begin r = {32{rm[31]}}; co = rm[31]; tag = "R5"; end
               else begin r = $signed(rm) >>> n; co = rm[n - 1]; tag = "R3"; end
        default: if (n == 0) begin r = {c, rm[31:1]}; co = rm[0]; tag = "R6"; end
                 else begin r = (rm >> n) | (rm << (32 - n)); co = rm[n - 1]; tag = "R3"; end
      endcase
      return;
    end
    n = int'(rs);
    if (n == 0) begin r = rm; co = c; tag = "R7"; return; end
    case (f[6:5])
      2'b00: if (n < 32) begin r = rm << n; co = rm[32 - n]; tag = "R3"; end
             else if (n == 32) begin r = 32'd0; co = rm[0]; tag = "R8"; end
             else begin r = 32'd0; co = 1'b0; tag = "R8"; end
      2'b01: if (n < 32) begin r = rm >> n; co = rm[n - 1]; tag = "R3"; end
             else if (n == 32) begin r = 32'd0; co = rm[31]; tag = "R8"; end
             else begin r = 32'd0; co = 1'b0; tag = "R8"; end
      2'b10: if (n < 32) begin r = $signed(rm) >>> n; co = rm[n - 1]; tag = "R3"; end
             else begin r = {32{rm[31]}}; co = rm[31]; tag = "R9"; end
      default: begin
        k = n % 32;
        if (k == 0) begin r = rm; co = rm[31]; end
        else begin r = (rm >> k) | (rm << (32 - k)); co = rm[k - 1]; end
        tag = "R10";
      end
    endcase
  endfunction

  task automatic run_vec(input logic [11:0] f, input logic imm, input logic [31:0] rm,
      input logic [7:0] rs, input logic c, input logic inv, input logic sf,
      input logic [3:0] d, input logic n0, input logic z0);
    logic [31:0] r, exp_op;
    logic        co, en, ez, ec, er;
    string       tag;
    @(negedge clk);
    opnd_field = f; use_imm = imm; rm_val = rm; rs_low = rs; c_in = c;
    mov_not = inv; set_flags = sf; dest_idx = d; n_in = n0; z_in = z0;
    #1;
    ref_shift(f, imm, rm, rs, c, r, co, tag);
    exp_op = inv ? ~r : r;  // R11: inversion after the shifter, carry untouched
    if (inv) tag = {tag, "/R11"};
    checks++;
    if (operand !== exp_op || shift_c !== co) begin
      fails++;
      $display("FAIL %s: operand=%h c=%b expected operand=%h c=%b (f=%h imm=%b rm=%h rs=%0d)",
               tag, operand, shift_c, exp_op, co, f, imm, rm, rs);
    end
    // R12 / R13 flag behaviour
    en = n0; ez = z0; ec = c; er = 1'b0;
    if (sf && d == 4'd15) er = 1'b1;
    else if (sf) begin en = exp_op[31]; ez = (exp_op == 32'd0); ec = co; end
    checks++;
    if (n_next !== en || z_next !== ez || c_next !== ec || restore_req !== er) begin
      fails++;
      $display("FAIL %s: nzc=%b%b%b rst=%b expected nzc=%b%b%b rst=%b",
               (sf && d == 4'd15) ? "R13" : "R12",
               n_next, z_next, c_next, restore_req, en, ez, ec, er);
    end
  endtask

  initial begin
    logic [31:0] rms [4];
    int amts [6];
    rms  = '{32'h8000_0001, 32'h7FFF_FFFE, 32'h0000_0000, 32'hA5C3_3C5A};
    amts = '{0, 1, 31, 32, 33, 255};
    // Idle state: all-zero inputs give operand 0 and held flags (R12)
    run_vec(12'h000, 1'b0, 32'd0, 8'd0, 1'b0, 1'b0, 1'b0, 4'd0, 1'b0, 1'b0);
    // R1, R2: every rotate value
    for (int rot = 0; rot < 16; rot++)
      foreach (rms[i])
        for (int cc = 0; cc < 2; cc++)
          run_vec({rot[3:0], rms[i][7:0] | 8'h81 & {8{cc[0]}}}, 1'b1, 32'd0, 8'd0,
                  cc[0], 1'b0, 1'b1, 4'd2, 1'b0, 1'b0);
    // R3..R6: immediate amounts incl. zero codes
    for (int t = 0; t < 4; t++)
      foreach (rms[i])
        for (int cc = 0; cc < 2; cc++) begin
          run_vec({5'd0,  t[1:0], 1'b0, 4'h3}, 1'b0, rms[i], 8'd0, cc[0], 1'b0, 1'b1, 4'd1, 1'b1, 1'b1);
          run_vec({5'd1,  t[1:0], 1'b0, 4'h3}, 1'b0, rms[i], 8'd0, cc[0], 1'b0, 1'b1, 4'd1, 1'b0, 1'b0);
          run_vec({5'd16, t[1:0], 1'b0, 4'h3}, 1'b0, rms[i], 8'd0, cc[0], 1'b1, 1'b1, 4'd1, 1'b0, 1'b0);
          run_vec({5'd31, t[1:0], 1'b0, 4'h3}, 1'b0, rms[i], 8'd0, cc[0], 1'b0, 1'b0, 4'd1, 1'b1, 1'b0);
        end
    // R3, R7..R10: register amounts 0, 1, 31, 32, 33, 255
    for (int t = 0; t < 4; t++)
      foreach (rms[i])
        foreach (amts[a])
          for (int cc = 0; cc < 2; cc++)
            run_vec({4'h5, 1'b0, t[1:0], 1'b1, 4'h3}, 1'b0, rms[i], amts[a][7:0],
                    cc[0], 1'b0, 1'b1, 4'd4, 1'b0, 1'b1);
    // R10: rotate by nonzero multiple of 32 (64)
    run_vec(12'h0F3, 1'b0, 32'h8000_0000, 8'd64, 1'b0, 1'b0, 1'b1, 4'd0, 1'b0, 1'b0);
    // R13: destination 15 with set-flags
    run_vec(12'h013, 1'b0, 32'h0, 8'd40, 1'b1, 1'b0, 1'b1, 4'd15, 1'b1, 1'b0);
    run_vec(12'h0FF, 1'b1, 32'h0, 8'd0,  1'b0, 1'b1, 1'b1, 4'd15, 1'b0, 1'b1);
    // Mixed random vectors (R11, R12, R13)
    for (int k = 0; k < 400; k++) begin
      logic [31:0] rv;
      rv = $urandom;
      run_vec(rv[11:0], rv[12], $urandom, rv[20:13], rv[21], rv[22], rv[23],
              rv[27:24], rv[28], rv[29]);
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule